// File: doc/BRIEF.md
# GPIO Port Bank with Change Interrupt

This block holds a bank of general-purpose pins split into byte-wide ports (two ports of eight pins by default). Each port carries four byte registers: a direction register, an output-value register, a read-inversion register and a read-only view of the pin levels. A host reaches them through a plain register port, which has a 3-bit address, write data, a write strobe, a read strobe and combinational read data. The block drives an output value and an output enable for each pin, and it samples the pin levels through a two-flop synchroniser.

Each port keeps a snapshot of its pin levels. The snapshot is taken whenever the host reads that port's input register. A small state machine per port, with states `ST_QUIET` and `ST_ALERT`, watches for any input-direction pin whose synchronised level differs from the snapshot. The transitions are: raise (QUIET to ALERT, on a mismatch with no read of that port), settle (ALERT to QUIET, when the mismatch goes away) and acknowledge (ALERT to QUIET, on a read of that port's input register). The active-low interrupt is low while any port is in `ST_ALERT`. A build parameter turns the drivers into open-drain drivers, which only ever pull low.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every direction bit is 1, so all pin enables are 0. Every output-value bit is 1, every inversion bit is 0, and the interrupt is high.
- R2: Address bits [2:1] select the register kind and bit [0] selects the port: 0/1 input, 2/3 output value, 4/5 inversion, 6/7 direction. Writes to kinds 1 to 3 store the data, and reads of them return the stored byte.
- R3: A direction bit of 0 enables that pin's driver with the stored output bit as its value. A direction bit of 1 disables the driver, and the pin is then an input. In the push-pull build, the pin output value always shows the output register.
- R4: A read of an input register returns the synchronised pin level XOR the port's inversion bits. This holds for pins set as outputs as well as for inputs.
- R5: Writes to addresses 0 and 1 change no register, no pin output and no pin enable.
- R6: The interrupt goes low three clocks after an input-direction pin changes to differ from its port snapshot.
- R7: Pins with direction 0 never cause the interrupt.
- R8: A read of a port's input register loads that port's snapshot and clears that port's alert. It does not affect the other port's alert.
- R9: A differing input pin that returns to its snapshot level releases the interrupt, with no read needed.
- R10: Switching a pin from output to input raises the interrupt if its level differs from the snapshot.
- R11: With the open-drain option, the pin enable is 1 only for a pin with direction 0 and output bit 0, and the driven value is always 0.
- R12: Snapshots reset to all zeros, so a pin held high through reset raises the interrupt once it is configured as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; an input-register read loads the snapshot |
| rdata | output | 8 | Combinational read data for addr |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin drive enables |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
The hardest states to reach are those where the two ports' snapshots diverge from each other. One example is a pending alert on one port that must survive a read of the other port. Another is a stale snapshot bit exposed when a pin's direction flips from output to input. Directed sequences build these states deliberately: they drive both ports' pins away from their snapshots, read one port and then the other, and park a mismatching level on a pin while it is an output before releasing it. Randomised operations then mix writes, reads and pin changes against a bench-side model of the registers and snapshots.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    typedef enum logic [1:0] {
        K_INPUT    = 2'd0,
        K_OUTPUT   = 2'd1,
        K_POLARITY = 2'd2,
        K_CONFIG   = 2'd3
    } reg_kind_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_ALERT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W     = 8,
    parameter bit OPEN_DRAIN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_out,
    input  logic              wr_pol,
    input  logic              wr_cfg,
    input  logic [PORT_W-1:0] wdata,
    input  logic              rd_in,
    input  logic [PORT_W-1:0] pin_s,
    output logic [PORT_W-1:0] out_q,
    output logic [PORT_W-1:0] pol_q,
    output logic [PORT_W-1:0] cfg_q,
    output logic [PORT_W-1:0] in_view,
    output logic [PORT_W-1:0] drv_val,
    output logic [PORT_W-1:0] drv_en,
    output logic              alert
);
    irq_state_e        st_q, st_d;
    logic [PORT_W-1:0] snap_q;
    logic              differs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '1;
            pol_q  <= '0;
            cfg_q  <= '1;
            snap_q <= '0;
        end else begin
            if (wr_out) out_q  <= wdata;
            if (wr_pol) pol_q  <= wdata;
            if (wr_cfg) cfg_q  <= wdata;
            if (rd_in)  snap_q <= pin_s;
        end
    end

    assign differs = |((pin_s ^ snap_q) & cfg_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    // next state and outputs
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (!rd_in && differs) st_d = ST_ALERT;
            ST_ALERT: if (rd_in || !differs) st_d = ST_QUIET;
        endcase
        alert   = (st_q == ST_ALERT);
        in_view = pin_s ^ pol_q;
    end

    generate
        if (OPEN_DRAIN) begin : g_od
            assign drv_en  = ~cfg_q & ~out_q;
            assign drv_val = '0;
        end else begin : g_pp
            assign drv_en  = ~cfg_q;
            assign drv_val = out_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PORT_W     = 8,
    parameter int NUM_PORTS  = 2,
    parameter bit OPEN_DRAIN = 1'b0,
    localparam int PSEL_W    = $clog2(NUM_PORTS),
    localparam int ADDR_W    = PSEL_W + 2,
    localparam int PIN_W     = PORT_W * NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic              irq_n
);
    reg_kind_e         kind;
    logic [PSEL_W-1:0] psel;
    logic [PIN_W-1:0]  pin_s;
    logic [PIN_W-1:0]  cfg_flat;
    logic [NUM_PORTS-1:0] alert_vec;
    logic [PORT_W-1:0] out_a  [NUM_PORTS];
    logic [PORT_W-1:0] pol_a  [NUM_PORTS];
    logic [PORT_W-1:0] cfg_a  [NUM_PORTS];
    logic [PORT_W-1:0] view_a [NUM_PORTS];

    assign kind = reg_kind_e'(addr[ADDR_W-1:PSEL_W]);
    assign psel = addr[PSEL_W-1:0];

    gpio_sync #(.WIDTH(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic hit;
            assign hit = (psel == PSEL_W'(p));
            gpio_port #(.PORT_W(PORT_W), .OPEN_DRAIN(OPEN_DRAIN)) u_port (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_out  (wr_en && hit && kind == K_OUTPUT),
                .wr_pol  (wr_en && hit && kind == K_POLARITY),
                .wr_cfg  (wr_en && hit && kind == K_CONFIG),
                .wdata   (wdata),
                .rd_in   (rd_en && hit && kind == K_INPUT),
                .pin_s   (pin_s[p*PORT_W +: PORT_W]),
                .out_q   (out_a[p]),
                .pol_q   (pol_a[p]),
                .cfg_q   (cfg_a[p]),
                .in_view (view_a[p]),
                .drv_val (pin_out[p*PORT_W +: PORT_W]),
                .drv_en  (pin_oe[p*PORT_W +: PORT_W]),
                .alert   (alert_vec[p])
            );
            assign cfg_flat[p*PORT_W +: PORT_W] = cfg_a[p];
        end
    endgenerate

    always_comb begin
        unique case (kind)
            K_INPUT:    rdata = view_a[psel];
            K_OUTPUT:   rdata = out_a[psel];
            K_POLARITY: rdata = pol_a[psel];
            K_CONFIG:   rdata = cfg_a[psel];
        endcase
    end

    assign irq_n = ~(|alert_vec);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int PORT_W     = 8,
    parameter int NUM_PORTS  = 2,
    parameter bit OPEN_DRAIN = 1'b0,
    localparam int PSEL_W    = $clog2(NUM_PORTS),
    localparam int ADDR_W    = PSEL_W + 2,
    localparam int PIN_W     = PORT_W * NUM_PORTS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic [PORT_W-1:0]    wdata,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [PIN_W-1:0]     pin_out,
    input logic [PIN_W-1:0]     pin_oe,
    input logic                 irq_n,
    input logic [PIN_W-1:0]     cfg_flat,
    input logic [NUM_PORTS-1:0] alert_vec
);
    localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_OUT0 = ADDR_W'(1 << PSEL_W);
    localparam logic [ADDR_W-1:0] A_CFG0 = ADDR_W'(3 << PSEL_W);

    AST_CFG_DISABLES_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CFG0) |=> ((pin_oe[PORT_W-1:0] & $past(wdata)) == '0)); // R3

    AST_OUT_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!OPEN_DRAIN && wr_en && addr == A_OUT0) |=> (pin_out[PORT_W-1:0] == $past(wdata))); // R3

    AST_INPUT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:PSEL_W] == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out))); // R5

    AST_OUTPUTS_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat == '0) |=> irq_n); // R7

    AST_READ_ACKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_IN0) |=> !alert_vec[0]); // R8
endmodule

bind gpio_bank gpio_bank_chk #(
    .PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .OPEN_DRAIN(OPEN_DRAIN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n),
    .cfg_flat(cfg_flat), .alert_vec(alert_vec)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] pins = '0;
    logic [7:0]  rdata, rdata_od;
    logic [15:0] pin_out, pin_oe, od_out, od_oe;
    logic        irq_n, irq_n_od;

    logic [15:0] m_out, m_pol, m_cfg, m_snap;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .pin_in(pins), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_n(irq_n)
    );

    gpio_bank #(.OPEN_DRAIN(1'b1)) u_gpio_bank_od (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata_od), .pin_in(pins), .pin_out(od_out),
        .pin_oe(od_oe), .irq_n(irq_n_od)
    );

    function automatic logic exp_irq_n();
        return ~(|((pins ^ m_snap) & m_cfg));
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_pins();
        check("R3 pin_oe", pin_oe, ~m_cfg);
        check("R3 pin_out", pin_out, m_out);
        check("R11 od_oe", od_oe, ~m_cfg & ~m_out);
        check("R11 od_out", od_out, 16'h0000);
        check("R6 irq_n", {15'd0, irq_n}, {15'd0, exp_irq_n()});
        check("R6 irq_n od", {15'd0, irq_n_od}, {15'd0, exp_irq_n()});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(logic [15:0] p);
        @(negedge clk);
        rst_n = 1'b0;
        pins  = p;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        m_out  = 16'hFFFF;
        m_pol  = 16'h0000;
        m_cfg  = 16'hFFFF;
        m_snap = 16'h0000;
        settle();
    endtask

    task automatic do_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a[2:1])
            2'd1: m_out[a[0]*8 +: 8] = d;
            2'd2: m_pol[a[0]*8 +: 8] = d;
            2'd3: m_cfg[a[0]*8 +: 8] = d;
            default: ;
        endcase
        settle();
    endtask

    task automatic do_read(logic [2:0] a);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        case (a[2:1])
            2'd0: exp = pins[a[0]*8 +: 8] ^ m_pol[a[0]*8 +: 8];
            2'd1: exp = m_out[a[0]*8 +: 8];
            2'd2: exp = m_pol[a[0]*8 +: 8];
            default: exp = m_cfg[a[0]*8 +: 8];
        endcase
        #1;
        check((a[2:1] == 2'd0) ? "R4 input read" : "R2 reg read", {8'd0, rdata}, {8'd0, exp});
        @(negedge clk);
        rd_en = 1'b0;
        if (a[2:1] == 2'd0) m_snap[a[0]*8 +: 8] = pins[a[0]*8 +: 8];
        settle();
    endtask

    task automatic set_pins(logic [15:0] p);
        @(negedge clk);
        pins = p;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        do_reset(16'h0000);
        // R1: reset state
        check("R1 oe after reset", pin_oe, 16'h0000);
        check("R1 irq after reset", {15'd0, irq_n}, 16'h0001);
        for (int a = 2; a < 8; a++) begin
            @(negedge clk); addr = 3'(a); #1;
            check("R1 reset value", {8'd0, rdata}, {8'd0, (a >= 6 || a < 4) ? 8'hFF : 8'h00});
        end

        // R5: writes to input registers ignored
        set_pins(16'h3C5A);
        do_read(3'd0); do_read(3'd1);
        do_write(3'd0, 8'h00);
        do_write(3'd1, 8'hFF);
        check_pins();
        do_read(3'd2); do_read(3'd3); do_read(3'd6); do_read(3'd7); // R5 registers unchanged
        do_read(3'd0); do_read(3'd1);

        // R4: input view of output-direction pins, with inversion
        do_write(3'd6, 8'h00);
        do_write(3'd4, 8'h0F);
        set_pins(16'h3CA5);
        check_pins();
        do_read(3'd0);

        // R8: per-port acknowledge
        do_write(3'd6, 8'hFF);
        do_read(3'd0); do_read(3'd1);
        set_pins(pins ^ 16'h0101);
        check("R8 both pending", {15'd0, irq_n}, 16'h0000);
        do_read(3'd0);
        check("R8 port1 survives port0 read", {15'd0, irq_n}, 16'h0000);
        do_read(3'd1);
        check("R8 cleared after both", {15'd0, irq_n}, 16'h0001);

        // R9: return to snapshot level
        set_pins(pins ^ 16'h0040);
        check("R9 raised", {15'd0, irq_n}, 16'h0000);
        set_pins(pins ^ 16'h0040);
        check("R9 released", {15'd0, irq_n}, 16'h0001);

        // R7 then R10: mismatch parked on output pin, released as input
        do_write(3'd7, 8'hF7);
        set_pins(pins ^ 16'h0800);
        check("R7 output pin silent", {15'd0, irq_n}, 16'h0001);
        do_write(3'd7, 8'hFF);
        check("R10 switch to input", {15'd0, irq_n}, 16'h0000);
        do_read(3'd1);
        check_pins();

        // R12: pin high through reset
        do_reset(16'h8001);
        check("R12 irq from reset snapshot", {15'd0, irq_n}, 16'h0000);
        do_read(3'd0); do_read(3'd1);
        check_pins();

        // randomised mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: do_write(3'($urandom_range(0, 7)), 8'($urandom));
                1: do_read(3'($urandom_range(0, 7)));
                2: set_pins(pins ^ (16'h1 << $urandom_range(0, 15)));
                default: set_pins(16'($urandom));
            endcase
            check_pins();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule